// File: doc/BRIEF.md
# Programmable Parallel Port Controller

A CPU-attached controller for 24 general-purpose parallel lines, organised as two 8-bit ports (A and B) and a third 8-bit port (C) that is handled as two independent nibbles. The CPU reaches the block through an 8-bit data bus, a two-bit register address and active-low chip-select, read and write strobes. All state is clocked by a single write clock, and an active-high reset returns every line to input.

Each port exposes its pin input, its output register and a drive enable on the port side; pads and tri-state buffers live outside. Lines are split into two groups: group A owns port A and the upper nibble of port C, and group B owns port B and the lower nibble. A configuration write chooses the direction of each of the four pieces independently and stores the mode fields of both groups. A second write format forces a single port C line high or low without disturbing its neighbours. Inputs of ports A and B are sampled into a holding register on every clock edge, while port C inputs are read straight from the pins.

Top module: `ppio_ctrl`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the configuration word, for both reads and writes.
- R2: While reset is high and after it, until the next configuration write, all drive enables are 0, all output registers are 0 and the configuration word reads back as 0x9B (every piece input, both modes 0).
- R3: A read of address 3 returns bit 7 as 1 and bits 6..0 as last stored.
- R4: A write to address 3 with bit 7 = 1 stores bits 6..0: bits 6..5 group A mode, bit 4 port A direction, bit 3 upper port C direction, bit 2 group B mode, bit 1 port B direction, bit 0 lower port C direction, 1 meaning input. Each of the 16 direction settings sets pa_oe, pc_oe[7:4], pb_oe and pc_oe[3:0] to the inverse of its bit.
- R5: Every configuration write with bit 7 = 1 clears the A, B and C output registers to 0.
- R6: A write to address 3 with bit 7 = 0 sets port C output bit number data[3:1] to data[0], leaves the other seven port C bits unchanged, and leaves the configuration word unchanged.
- R7: A write to address 0, 1 or 2 loads the whole byte into that port's output register, whatever the direction.
- R8: Reading a port (or port C nibble) set as output returns its output register; reading port A or B set as input returns the pins as sampled at the previous clock edge; reading a port C nibble set as input returns the current pins.
- R9: With chip select high, writes change no register and the data output is 0; the data output is also 0 whenever no read is active.
- R10: The stored mode fields read back unchanged and do not alter the direction of any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock for all registers |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| din | input | 8 | CPU write data |
| dout | output | 8 | CPU read data, 0 when not reading |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output register |
| pc_oe | output | 8 | Port C drive enables, one per line |

## Verification
The assertions watch, on every cycle, that a single-bit command leaves the configuration word alone and flips at most one port C bit, that a configuration write empties all output registers, that chip select high freezes every register and enable, that the configuration readback always carries bit 7 set, and that the enables are off right after reset. Only the bench scenarios show the address map, the full encoding of the 16 direction settings, the one-cycle delay of the A and B input samples against the immediate port C pins, and the per-nibble mixing of pin and register values on port C reads.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

   typedef enum logic [1:0] {
      SEL_A    = 2'd0,
      SEL_B    = 2'd1,
      SEL_C    = 2'd2,
      SEL_CFG  = 2'd3
   } sel_e;

   // Stored configuration, bits 6..0 of a mode-set write.
   typedef struct packed {
      logic [1:0] ga_mode;
      logic       a_in;
      logic       cu_in;
      logic       gb_mode;
      logic       b_in;
      logic       cl_in;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{ga_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                  gb_mode: 1'b0,  b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/ppio_cfg_reg.sv
module ppio_cfg_reg
   import ppio_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int SEL_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] wdata,
   output cfg_t              cfg,
   output logic              mode_set,
   output logic              bit_we,
   output logic [SEL_W-1:0]  bit_idx,
   output logic              bit_val
);

   assign mode_set = cfg_we &  wdata[DATA_W-1];
   assign bit_we   = cfg_we & ~wdata[DATA_W-1];
   assign bit_idx  = wdata[SEL_W:1];
   assign bit_val  = wdata[0];

   always_ff @(posedge clk) begin
      if (rst)
         cfg <= CFG_RESET;
      else if (mode_set)
         cfg <= cfg_t'(wdata[6:0]);
   end

   // R6: a single-bit command leaves the configuration untouched
   assert_bsr_keeps_cfg_R6: assert property (@(posedge clk) disable iff (rst)
      bit_we |=> $stable(cfg));

   // R4: a mode-set write lands in the configuration next cycle
   assert_mode_set_stores_R4: assert property (@(posedge clk) disable iff (rst)
      mode_set |=> (cfg == cfg_t'($past(wdata[6:0]))));

endmodule

// File: rtl/ppio_out_regs.sv
module ppio_out_regs #(
   parameter int DATA_W = 8,
   localparam int SEL_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic              wr_c,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mode_set,
   input  logic              bit_we,
   input  logic [SEL_W-1:0]  bit_idx,
   input  logic              bit_val,
   output logic [DATA_W-1:0] a_q,
   output logic [DATA_W-1:0] b_q,
   output logic [DATA_W-1:0] c_q
);

   always_ff @(posedge clk) begin
      if (rst || mode_set) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         if (wr_a) a_q <= wdata;
         if (wr_b) b_q <= wdata;
      end
   end

   // Port C: one flop per line so a single-bit command touches only its own line.
   for (genvar i = 0; i < DATA_W; i++) begin : g_cbit
      always_ff @(posedge clk) begin
         if (rst || mode_set)
            c_q[i] <= 1'b0;
         else if (wr_c)
            c_q[i] <= wdata[i];
         else if (bit_we && (bit_idx == SEL_W'(i)))
            c_q[i] <= bit_val;
      end
   end

   // R5: a mode-set write empties all output registers
   assert_mode_clears_out_R5: assert property (@(posedge clk) disable iff (rst)
      mode_set |=> (a_q == '0 && b_q == '0 && c_q == '0));

   // R6: a single-bit command changes at most one port C line
   assert_bsr_one_bit_R6: assert property (@(posedge clk) disable iff (rst)
      (bit_we && !wr_c) |=> ($countones(c_q ^ $past(c_q)) <= 1));

endmodule

// File: rtl/ppio_read_path.sv
module ppio_read_path
   import ppio_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit LATCH_INPUTS = 1'b1,
   localparam int NIB         = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  sel_e              sel,
   input  cfg_t              cfg,
   input  logic [DATA_W-1:0] a_q,
   input  logic [DATA_W-1:0] b_q,
   input  logic [DATA_W-1:0] c_q,
   input  logic [DATA_W-1:0] pa_in,
   input  logic [DATA_W-1:0] pb_in,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] a_src, b_src, c_view, mux;

   if (LATCH_INPUTS) begin : g_latched
      logic [DATA_W-1:0] a_hold, b_hold;
      always_ff @(posedge clk) begin
         if (rst) begin
            a_hold <= '0;
            b_hold <= '0;
         end else begin
            a_hold <= pa_in;
            b_hold <= pb_in;
         end
      end
      assign a_src = a_hold;
      assign b_src = b_hold;
   end else begin : g_direct
      assign a_src = pa_in;
      assign b_src = pb_in;
   end

   assign c_view = {cfg.cu_in ? pc_in[DATA_W-1:NIB] : c_q[DATA_W-1:NIB],
                    cfg.cl_in ? pc_in[NIB-1:0]      : c_q[NIB-1:0]};

   always_comb begin
      unique case (sel)
         SEL_A:   mux = cfg.a_in ? a_src : a_q;
         SEL_B:   mux = cfg.b_in ? b_src : b_q;
         SEL_C:   mux = c_view;
         default: mux = {1'b1, cfg};
      endcase
   end

   assign rdata = rd_en ? mux : '0;

   // R3: configuration readback always carries bit 7 set
   assert_cfg_read_msb_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_en && sel == SEL_CFG) |-> rdata[DATA_W-1]);

   // R9: the data output is quiet when no read is active
   assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (rst)
      !rd_en |-> (rdata == '0));

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
   import ppio_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit LATCH_INPUTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic              pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic              pb_oe,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] pc_oe
);

   localparam int NIB   = DATA_W / 2;
   localparam int SEL_W = $clog2(DATA_W);

   if (DATA_W != 8) begin : g_bad_width
      $error("ppio_ctrl: configuration format needs DATA_W of 8");
   end

   sel_e             sel;
   logic             wr_en, rd_en;
   cfg_t             cfg;
   logic             mode_set, bit_we, bit_val;
   logic [SEL_W-1:0] bit_idx;

   assign sel   = sel_e'(addr);
   assign wr_en = ~cs_n & ~wr_n;
   assign rd_en = ~cs_n & ~rd_n;

   ppio_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (wr_en && sel == SEL_CFG),
      .wdata    (din),
      .cfg      (cfg),
      .mode_set (mode_set),
      .bit_we   (bit_we),
      .bit_idx  (bit_idx),
      .bit_val  (bit_val)
   );

   ppio_out_regs #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst      (rst),
      .wr_a     (wr_en && sel == SEL_A),
      .wr_b     (wr_en && sel == SEL_B),
      .wr_c     (wr_en && sel == SEL_C),
      .wdata    (din),
      .mode_set (mode_set),
      .bit_we   (bit_we),
      .bit_idx  (bit_idx),
      .bit_val  (bit_val),
      .a_q      (pa_out),
      .b_q      (pb_out),
      .c_q      (pc_out)
   );

   ppio_read_path #(.DATA_W(DATA_W), .LATCH_INPUTS(LATCH_INPUTS)) u_rd (
      .clk   (clk),
      .rst   (rst),
      .rd_en (rd_en),
      .sel   (sel),
      .cfg   (cfg),
      .a_q   (pa_out),
      .b_q   (pb_out),
      .c_q   (pc_out),
      .pa_in (pa_in),
      .pb_in (pb_in),
      .pc_in (pc_in),
      .rdata (dout)
   );

   assign pa_oe = ~cfg.a_in;
   assign pb_oe = ~cfg.b_in;

   for (genvar i = 0; i < DATA_W; i++) begin : g_c_oe
      if (i >= NIB) begin : g_hi
         assign pc_oe[i] = ~cfg.cu_in;
      end else begin : g_lo
         assign pc_oe[i] = ~cfg.cl_in;
      end
   end

   // R9: with chip select high no register or enable moves
   assert_cs_idle_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

   // R2: first cycle after reset has every line undriven
   assert_reset_inputs_R2: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!pa_oe && !pb_oe && pc_oe == '0));

endmodule

// File: tb/ppio_ctrl_test.sv
module ppio_ctrl_test;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst, cs_n, rd_n, wr_n;
   logic [1:0] addr;
   logic [7:0] din, dout;
   logic [7:0] pa_in, pa_out, pb_in, pb_out, pc_in, pc_out, pc_oe;
   logic       pa_oe, pb_oe;

   int nchk = 0;
   int nbad = 0;

   always #(CLK_P/2) clk = ~clk;

   ppio_ctrl uut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(din), .dout(dout),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   typedef struct packed {
      logic       rd;
      logic [1:0] adr;
      logic [7:0] dat;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 37;
   // Pins held at A: A5, B: 3C, C: 96 during the table.
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd3, 8'h80, 4'd4},   // R4 all output
      '{1'b1, 2'd3, 8'h80, 4'd3},   // R3 readback
      '{1'b1, 2'd0, 8'h00, 4'd5},   // R5 cleared
      '{1'b0, 2'd0, 8'h5A, 4'd7},   // R7
      '{1'b1, 2'd0, 8'h5A, 4'd1},   // R1 port A
      '{1'b0, 2'd1, 8'hC3, 4'd7},   // R7
      '{1'b1, 2'd1, 8'hC3, 4'd1},   // R1 port B
      '{1'b0, 2'd2, 8'h7E, 4'd7},   // R7
      '{1'b1, 2'd2, 8'h7E, 4'd1},   // R1 port C
      '{1'b0, 2'd3, 8'h0F, 4'd6},   // R6 set bit 7
      '{1'b1, 2'd2, 8'hFE, 4'd6},
      '{1'b0, 2'd3, 8'h08, 4'd6},   // R6 clear bit 4
      '{1'b1, 2'd2, 8'hEE, 4'd6},
      '{1'b1, 2'd3, 8'h80, 4'd6},   // R6 config unchanged
      '{1'b0, 2'd3, 8'h9B, 4'd4},   // R4 all input
      '{1'b1, 2'd0, 8'hA5, 4'd8},   // R8 latched pins
      '{1'b1, 2'd1, 8'h3C, 4'd8},
      '{1'b1, 2'd2, 8'h96, 4'd8},
      '{1'b1, 2'd3, 8'h9B, 4'd3},
      '{1'b0, 2'd3, 8'h90, 4'd5},   // R5 A in, rest out
      '{1'b1, 2'd0, 8'hA5, 4'd8},
      '{1'b1, 2'd1, 8'h00, 4'd5},
      '{1'b1, 2'd2, 8'h00, 4'd5},
      '{1'b0, 2'd1, 8'h11, 4'd7},
      '{1'b1, 2'd1, 8'h11, 4'd7},
      '{1'b0, 2'd3, 8'h89, 4'd4},   // C both nibbles in
      '{1'b0, 2'd2, 8'hFF, 4'd7},
      '{1'b1, 2'd2, 8'h96, 4'd8},   // R8 pins, not register
      '{1'b0, 2'd3, 8'h88, 4'd4},   // upper in, lower out
      '{1'b0, 2'd2, 8'h0F, 4'd7},
      '{1'b1, 2'd2, 8'h9F, 4'd8},
      '{1'b0, 2'd3, 8'h81, 4'd4},   // upper out, lower in
      '{1'b0, 2'd2, 8'hF0, 4'd7},
      '{1'b1, 2'd2, 8'hF6, 4'd8},
      '{1'b0, 2'd3, 8'hE4, 4'd10},  // R10 mode fields
      '{1'b1, 2'd3, 8'hE4, 4'd10},
      '{1'b1, 2'd0, 8'h00, 4'd5}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
      @(negedge clk);
      cs_n = sel_n; wr_n = 1'b0; addr = a; din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      #1 chk(tag, dout, exp);
      #1 cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
   endtask

   initial begin
      #(CLK_P * 100000);
      nbad++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin
      rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      addr = 2'd0; din = 8'h00;
      pa_in = 8'hA5; pb_in = 8'h3C; pc_in = 8'h96;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R2 enables in reset", {pa_oe, pb_oe, 6'b0}, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      chk("R2 pc_oe", pc_oe, 8'h00);
      chk("R2 pa_out", pa_out, 8'h00);
      rd(2'd3, 8'h9B, "R2 config after reset");

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].rd)
            rd(VECS[i].adr, VECS[i].dat, $sformatf("vector %0d R%0d", i, VECS[i].req));
         else
            wr(VECS[i].adr, VECS[i].dat, 1'b0);
      end

      // R10: mode fields set, all directions output
      chk("R10 enables", {pa_oe, pb_oe, 6'b0}, 8'hC0);
      chk("R10 pc_oe", pc_oe, 8'hFF);

      // R4: every direction combination
      for (int k = 0; k < 16; k++) begin
         logic [3:0] d;
         d = 4'(k);
         wr(2'd3, {1'b1, 2'b00, d[3], d[2], 1'b0, d[1], d[0]}, 1'b0);
         chk($sformatf("R4 combo %0d A/B", k), {6'b0, pa_oe, pb_oe}, {6'b0, ~d[3], ~d[1]});
         chk($sformatf("R4 combo %0d C", k), pc_oe, {{4{~d[2]}}, {4{~d[0]}}});
      end

      // R9: chip select high blocks writes and reads
      wr(2'd3, 8'h80, 1'b0);
      wr(2'd0, 8'h33, 1'b0);
      wr(2'd0, 8'h44, 1'b1);
      chk("R9 port A write ignored", pa_out, 8'h33);
      wr(2'd3, 8'h9B, 1'b1);
      chk("R9 config write ignored", {7'b0, pa_oe}, 8'h01);
      chk("R9 no clear by ignored write", pa_out, 8'h33);
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b0; addr = 2'd0;
      #1 chk("R9 read without select", dout, 8'h00);
      #1 rd_n = 1'b1;

      // R8: port A input sampled on the clock, port C pins direct
      wr(2'd3, 8'h9B, 1'b0);
      @(negedge clk);
      pa_in = 8'h11; pc_in = 8'h3D;
      cs_n = 1'b0; rd_n = 1'b0; addr = 2'd0;
      #1 chk("R8 port A before edge", dout, 8'hA5);
      addr = 2'd2;
      #1 chk("R8 port C immediate", dout, 8'h3D);
      cs_n = 1'b1; rd_n = 1'b1;
      rd(2'd0, 8'h11, "R8 port A after edge");

      // R2: reset in mid operation
      wr(2'd3, 8'h80, 1'b0);
      wr(2'd1, 8'h5C, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R2 pb_out after reset", pb_out, 8'h00);
      chk("R2 enables after reset", {pa_oe, pb_oe, 6'b0}, 8'h00);
      rd(2'd3, 8'h9B, "R2 config after second reset");

      summary();
      $finish;
   end

endmodule